// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Loading

This block holds a 256-entry colour table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue part. Software loads the table through two word-wide registers on a write-only bus window. The first register picks an entry. The second takes one colour part per write, always red first, then green, then blue. Only the most significant byte of each bus word is used.

After the blue part the block moves on to the next entry by itself, so a full table can be streamed with one pointer write. A pointer write at any time restarts the part sequence at red.

The display side presents an 8-bit pixel code every clock. One clock later it gets back the 24-bit colour of that entry. The colour is packed with red in the top byte, green in the middle byte and blue in the low byte. Reads of the bus window always return zero.

Top module: `clut_prog`

## Requirements
- R1: A bus write with `bus_wr_en` high and `bus_addr` = 0 loads the entry pointer from `bus_wdata[31:24]`. It also returns the part sequence to red.
- R2: Each bus write to `bus_addr` = 4 stores `bus_wdata[31:24]` into one part of the pointed entry. Successive writes fill red, then green, then blue.
- R3: The blue write advances the entry pointer by one, wrapping from 255 to 0. The next data write then fills red.
- R4: `bus_rdata` is zero in every cycle.
- R5: Bus writes to any offset other than 0 and 4 change no table entry, no pointer and no sequence position. This includes the misaligned offsets 1 to 3.
- R6: While `rst_n` is low, every entry becomes black (0x000000) except entry 255, which becomes white (0xFFFFFF). The pointer and the sequence also reset, so the first data write after reset fills red of entry 0.
- R7: `pix_rgb` shows the colour of the entry named by `pix_idx` at the previous rising clock edge. The colour is packed as {red, green, blue}, with red in bits [23:16] and blue in bits [7:0]. `pix_rgb` is 0 while in reset.
- R8: A data write and a lookup of the same entry in the same cycle return the old colour on that lookup. The updated colour appears on the lookup one cycle later.
- R9: A pointer write in the middle of the sequence keeps any parts already written to the previous entry. The following data write fills red of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe; a write is taken in each cycle this is high |
| bus_addr | input | 4 | Byte offset of the write inside the register window |
| bus_wdata | input | 32 | Write data; only bits [31:24] are used |
| bus_rdata | output | 32 | Read data; always zero |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Registered colour of the looked-up entry, {red, green, blue} |

## Verification
The block's internal state is the pointer, the sequence position and the table contents. A wrong value in any of them shows up only through the colours returned by later lookups.

A sequence step that slips puts a byte into the wrong part of an entry. A pointer that goes astray puts a whole colour into a neighbouring entry. Either error is visible on the lookup two cycles after the bad write: one cycle for the write and one for the lookup register.

The bench therefore follows every write with a lookup of the entry a correct design would have touched. After writes that must be ignored, it also checks the entries and the sequence position that a broken decode would have disturbed.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Which colour part the next data write fills
  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2
  } comp_step_e;

  // Register offsets inside the bus window
  localparam int unsigned OFS_POINTER = 0;
  localparam int unsigned OFS_DATA    = 4;

  // Lane numbering of the part-enable vector: red is the top lane
  localparam int unsigned LANES = 3;

endpackage

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              ptr_we,
  output logic              dat_we
);

  always_comb begin
    ptr_we = wr_en && (addr == ADDR_W'(OFS_POINTER));
    dat_we = wr_en && (addr == ADDR_W'(OFS_DATA));
  end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic             dat_we,
  input  logic [IDX_W-1:0] ptr_val,
  output logic [IDX_W-1:0] cur_idx,
  output comp_step_e       cur_step,
  output logic [LANES-1:0] lane_we
);

  logic [IDX_W-1:0] idx_q, idx_d;
  comp_step_e       step_q, step_d;
  logic             seq_en;

  // Next-state logic
  always_comb begin
    idx_d  = idx_q;
    step_d = step_q;
    if (ptr_we) begin
      idx_d  = ptr_val;
      step_d = STEP_RED;
    end else if (dat_we) begin
      unique case (step_q)
        STEP_RED: step_d = STEP_GRN;
        STEP_GRN: step_d = STEP_BLU;
        STEP_BLU: begin
          step_d = STEP_RED;
          idx_d  = idx_q + IDX_W'(1);
        end
        default:  step_d = STEP_RED;
      endcase
    end
  end

  assign seq_en = ptr_we | dat_we;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= STEP_RED;
    end else if (seq_en) begin
      idx_q  <= idx_d;
      step_q <= step_d;
    end
  end

  // Part-enable lanes: bit 2 red, bit 1 green, bit 0 blue
  always_comb begin
    lane_we = '0;
    if (dat_we) begin
      unique case (step_q)
        STEP_RED: lane_we = 3'b100;
        STEP_GRN: lane_we = 3'b010;
        STEP_BLU: lane_we = 3'b001;
        default:  lane_we = 3'b000;
      endcase
    end
  end

  assign cur_idx  = idx_q;
  assign cur_step = step_q;

  // R1: pointer write loads the byte and restarts at red
  p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (idx_q == $past(ptr_val)) && (step_q == STEP_RED));

  // R2: red and green steps advance the sequence, pointer held
  p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !ptr_we && step_q != STEP_BLU)
      |=> (step_q != STEP_RED) && $stable(idx_q));

  // R2: at most one colour part written per cycle
  p_lane_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

  // R3: blue step wraps to red and bumps the pointer
  p_blue_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !ptr_we && step_q == STEP_BLU)
      |=> (step_q == STEP_RED) && (idx_q == $past(idx_q) + IDX_W'(1)));

  // R2: sequence never enters the unused encoding
  p_step_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != comp_step_e'(2'd3));

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_we,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [COMP_W-1:0]       wr_byte,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [LANES*COMP_W-1:0] rd_rgb
);

  localparam int unsigned DEPTH     = 1 << IDX_W;
  localparam int unsigned WHITE_IDX = DEPTH - 1;

  logic [LANES-1:0][COMP_W-1:0] tbl_q [DEPTH];
  logic [LANES*COMP_W-1:0]      rgb_q;
  logic                         tbl_en;

  assign tbl_en = |lane_we;

  // Table storage: reset preset, per-lane byte writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        tbl_q[e] <= (e == WHITE_IDX) ? '1 : '0;
      end
    end else if (tbl_en) begin
      for (int c = 0; c < LANES; c++) begin
        if (lane_we[c]) tbl_q[wr_idx][c] <= wr_byte;
      end
    end
  end

  // Registered pixel lookup, {red, green, blue}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= tbl_q[rd_idx];
  end

  assign rd_rgb = rgb_q;

endmodule

// File: rtl/clut_prog.sv
module clut_prog
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr_en,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [IDX_W-1:0]        pix_idx,
  output logic [LANES*COMP_W-1:0] pix_rgb
);

  localparam int unsigned RGB_W = LANES * COMP_W;

  logic             ptr_we, dat_we;
  logic [IDX_W-1:0] cur_idx;
  comp_step_e       cur_step;
  logic [LANES-1:0] lane_we;
  logic [RGB_W-1:0] rgb;
  logic             unused_wdata_low;

  // Only the top byte of the bus word carries data
  assign unused_wdata_low = ^bus_wdata[DATA_W-COMP_W-1:0];

  clut_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en  (bus_wr_en),
    .addr   (bus_addr),
    .ptr_we (ptr_we),
    .dat_we (dat_we)
  );

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_we   (ptr_we),
    .dat_we   (dat_we),
    .ptr_val  (bus_wdata[DATA_W-1 -: IDX_W]),
    .cur_idx  (cur_idx),
    .cur_step (cur_step),
    .lane_we  (lane_we)
  );

  clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we (lane_we),
    .wr_idx  (cur_idx),
    .wr_byte (bus_wdata[DATA_W-1 -: COMP_W]),
    .rd_idx  (pix_idx),
    .rd_rgb  (rgb)
  );

  assign pix_rgb   = rgb;
  assign bus_rdata = '0;

  // R5: writes to other offsets leave pointer and sequence alone
  p_other_ofs_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr != ADDR_W'(OFS_POINTER) && bus_addr != ADDR_W'(OFS_DATA))
      |=> $stable(cur_idx) && $stable(cur_step));

  // R5: decoder never raises a part enable for another offset
  p_no_lane_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(OFS_DATA)) |-> (lane_we == '0));

endmodule

// File: tb/clut_prog_bench.sv
module clut_prog_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;

  int n_checks;
  int n_errors;
  bit done;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  int         midx;
  int         mstep;
  int         last_ent;

  clut_prog u_clut_prog (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_idx   (pix_idx),
    .pix_rgb   (pix_rgb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Write vectors: {offset, data byte}
  localparam int NVEC = 17;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'h0, 8'h10}, {4'h4, 8'hAA}, {4'h4, 8'h55}, {4'h4, 8'h0F},
    {4'h4, 8'h12}, {4'h8, 8'hEE}, {4'h4, 8'h34}, {4'hC, 8'h99},
    {4'h4, 8'h56}, {4'h0, 8'h80}, {4'h4, 8'hC3}, {4'h0, 8'h81},
    {4'h4, 8'h7E}, {4'h2, 8'hFF}, {4'h4, 8'h01}, {4'h4, 8'h02},
    {4'h1, 8'h3C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_rgb(input int e);
    return {mr[e], mg[e], mb[e]};
  endfunction

  task automatic model_reset();
    for (int e = 0; e < 256; e++) begin
      mr[e] = (e == 255) ? 8'hFF : 8'h00;
      mg[e] = (e == 255) ? 8'hFF : 8'h00;
      mb[e] = (e == 255) ? 8'hFF : 8'h00;
    end
    midx  = 0;
    mstep = 0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    last_ent = midx;
    if (a == 4'h0) begin
      midx  = d;
      mstep = 0;
      last_ent = midx;
    end else if (a == 4'h4) begin
      case (mstep)
        0: begin mr[midx] = d; mstep = 1; end
        1: begin mg[midx] = d; mstep = 2; end
        default: begin mb[midx] = d; mstep = 0; midx = (midx + 1) % 256; end
      endcase
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = {d, 24'h5A_C3_96};
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_addr  = 4'h0;
    bus_wdata = 32'h0;
    model_write(a, d);
  endtask

  task automatic lookup(input logic [7:0] i, output logic [23:0] got);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    got = pix_rgb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 reset lookup output", {8'h0, pix_rgb}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] got;
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bus_wr_en = 1'b0;
    bus_addr = 4'h0;
    bus_wdata = 32'h0;
    pix_idx = 8'h00;
    model_reset();
    #1;
    check("R6 reset lookup output", {8'h0, pix_rgb}, 32'h0);
    check("R4 read zero in reset", bus_rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset contents
    lookup(8'h00, got); check("R6 entry 0 black", {8'h0, got}, 32'h0);
    lookup(8'hFF, got); check("R6 entry 255 white", {8'h0, got}, 32'h00FFFFFF);
    lookup(8'h07, got); check("R6 entry 7 black", {8'h0, got}, 32'h0);
    // R6: pointer and sequence start at entry 0, red
    bus_write(4'h4, 8'h5A);
    lookup(8'h00, got); check("R6 first data write to red of entry 0", {8'h0, got}, 32'h005A0000);

    // Vector walk: R1 R2 R5 R9
    for (int v = 0; v < NVEC; v++) begin
      bus_write(VEC[v][11:8], VEC[v][7:0]);
      check("R4 read zero", bus_rdata, 32'h0);
      lookup(8'(last_ent), got);
      check("R2 R5 R9 entry after vector", {8'h0, got}, {8'h0, model_rgb(last_ent)});
    end
    // R9: entry left mid-sequence keeps its red part
    lookup(8'h80, got); check("R9 partial entry kept", {8'h0, got}, 32'h00C30000);
    lookup(8'h10, got); check("R2 full entry order", {8'h0, got}, 32'h00AA550F);
    // R5: ignored writes did not shift the sequence; 0x81 filled, pointer at 0x82
    lookup(8'h81, got); check("R5 sequence unaffected", {8'h0, got}, 32'h007E0102);
    bus_write(4'h4, 8'h9D);
    lookup(8'h82, got); check("R5 pointer unaffected", {8'h0, got}, 32'h009D0000);

    // R3: wrap from 255 to 0
    bus_write(4'h0, 8'hFF);
    bus_write(4'h4, 8'h11);
    bus_write(4'h4, 8'h22);
    bus_write(4'h4, 8'h33);
    lookup(8'hFF, got); check("R3 entry 255 loaded", {8'h0, got}, 32'h00112233);
    bus_write(4'h4, 8'h44);
    lookup(8'h00, got); check("R3 wrap to entry 0 red", {8'h0, got}, 32'h00440000);

    // R8: write and lookup same entry in same cycle (pointer 0, green step)
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h66000000; pix_idx = 8'h00;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
    model_write(4'h4, 8'h66);
    check("R8 same-cycle lookup old", {8'h0, pix_rgb}, 32'h00440000);
    @(negedge clk);
    check("R8 next lookup new", {8'h0, pix_rgb}, 32'h00446600);

    // R7: one-cycle latency
    @(negedge clk);
    pix_idx = 8'h10;
    #1;
    check("R7 output holds before edge", {8'h0, pix_rgb}, 32'h00446600);
    @(negedge clk);
    check("R7 output after one edge", {8'h0, pix_rgb}, 32'h00AA550F);

    // R6: reset mid-run restores contents and pointer
    do_reset();
    lookup(8'h10, got); check("R6 entry cleared by reset", {8'h0, got}, 32'h0);
    lookup(8'hFF, got); check("R6 entry 255 white again", {8'h0, got}, 32'h00FFFFFF);
    bus_write(4'h4, 8'h21);
    lookup(8'h00, got); check("R6 sequence restarted", {8'h0, got}, 32'h00210000);
    check("R4 read zero end", bus_rdata, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule